// File: doc/BRIEF.md
# Fault Register Dump Walker

The walker captures first-failure diagnostic data from a set of hardware units after an error. On a start pulse it masters a simple 64-bit read port, one read outstanding at a time, and stores every (address, value) pair it reads into an external capture buffer through a write port. It reads three fixed global registers first: the global fault summary, the infrastructure unit configuration, and then the application unit configuration. After those it visits each unit in ascending order.

For every unit the walker reads the unit's primary fault register and its fault-enable register. It then reads a secondary fault register and a secondary enable register for each of the 64 primary bits. A mode input chooses between two cases. In one, every bit is read. In the other, only bits set in that unit's primary fault value are read. Records that do not fit in the buffer are dropped and flagged. Once the walk ends, all unwritten slots get an invalid marker. A one-cycle done pulse follows, and the number of real records is reported.

Top module: `fault_dump_walker`

## Requirements
- R1: After reset the block is idle: no read request, no buffer write, busy, done and overflow low, record count zero.
- R2: A walk reads the global fault address, then the infrastructure configuration address, then the application configuration address, in that order.
- R3: Units are visited in ascending order i = 0 .. NUM_UNITS-1. Each unit gets a read at (i<<24)|0x008, whose value is the primary fault mask, followed by a read at (i<<24)|0x018.
- R4: In selective mode (all_mode_i = 0, latched at start), each bit j set in the unit's primary fault mask is handled in ascending j, with a read at (i<<24)|(0x100+8j) followed by one at (i<<24)|(0x300+8j). Bits that are clear are skipped.
- R5: In all mode (all_mode_i = 1), both secondary reads are made for all 64 bits of every unit, whatever the mask holds.
- R6: Each read response becomes one buffer write carrying the read address and data, at slot indices 0, 1, 2, … in read order. The request and its address stay unchanged until acknowledged.
- R7: When a response arrives with all BUF_DEPTH slots used, it is dropped and overflow_o is set. The record count then equals BUF_DEPTH.
- R8: After the last read, every remaining slot up to BUF_DEPTH-1 is written with address 0xFFFFFFFF and an all-ones value.
- R9: done_o is high for exactly one cycle after filling ends, after which busy_o is low. rec_count_o holds the number of real records stored.
- R10: A start pulse while busy has no effect on the walk.
- R11: A new start clears the overflow flag and the record count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a walk when idle |
| all_mode_i | input | 1 | 1: read all secondary registers; 0: only flagged ones |
| rd_req_o | output | 1 | Read request, held until acknowledged |
| rd_addr_o | output | 32 | Read address |
| rd_ack_i | input | 1 | Read response valid |
| rd_data_i | input | 64 | Read response data |
| buf_we_o | output | 1 | Capture buffer write enable |
| buf_idx_o | output | $clog2(BUF_DEPTH) | Capture buffer slot |
| buf_addr_o | output | 32 | Record address field |
| buf_data_o | output | 64 | Record value field |
| busy_o | output | 1 | Walk or fill in progress |
| done_o | output | 1 | One-cycle completion pulse |
| overflow_o | output | 1 | Records were dropped |
| rec_count_o | output | $clog2(BUF_DEPTH+1) | Number of real records stored |

## Verification
The hardest point to reach from the ports is a walk whose record total lands exactly on the buffer boundary. One case leaves a single slot for the fill step, and another drops exactly one record. The bench gets there by choosing how many bits are set in each unit's primary fault value, which the responder model returns: one bit more or fewer moves the total by two records. The same bench also runs all mode, which overflows heavily. A second start pulse is sent mid-walk; if it restarted the walk, the writes would be duplicated.

// File: rtl/fdw_pkg.sv
package fdw_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_GLB,
    ST_ICFG,
    ST_ACFG,
    ST_UNIT_FLT,
    ST_UNIT_ENA,
    ST_SUB_FLT,
    ST_SUB_ENA,
    ST_FILL,
    ST_DONE
  } walk_st_e;

  localparam logic [31:0] INVALID_ADDR = 32'hFFFF_FFFF;
  localparam logic [23:0] OFF_UNIT_FLT = 24'h00_0008;
  localparam logic [23:0] OFF_UNIT_ENA = 24'h00_0018;
  localparam logic [23:0] OFF_SUB_FLT  = 24'h00_0100;
  localparam logic [23:0] OFF_SUB_ENA  = 24'h00_0300;
endpackage

// File: rtl/fdw_addr_gen.sv
module fdw_addr_gen
  import fdw_pkg::*;
#(
  parameter int          UNIT_W         = 4,
  parameter logic [31:0] GLB_FAULT_ADDR = 32'h0000_0028,
  parameter logic [31:0] INFRA_CFG_ADDR = 32'h0000_0000,
  parameter logic [31:0] APP_CFG_ADDR   = 32'h0200_0000
) (
  input  walk_st_e          st_i,
  input  logic [UNIT_W-1:0] unit_i,
  input  logic [5:0]        bit_i,
  output logic [31:0]       addr_o
);
  logic [7:0]  unit_field;
  logic [23:0] bit_off;

  assign unit_field = 8'(unit_i);
  assign bit_off    = {15'd0, bit_i, 3'd0};

  always_comb begin
    unique case (st_i)
      ST_GLB:      addr_o = GLB_FAULT_ADDR;
      ST_ICFG:     addr_o = INFRA_CFG_ADDR;
      ST_ACFG:     addr_o = APP_CFG_ADDR;
      ST_UNIT_FLT: addr_o = {unit_field, OFF_UNIT_FLT};
      ST_UNIT_ENA: addr_o = {unit_field, OFF_UNIT_ENA};
      ST_SUB_FLT:  addr_o = {unit_field, OFF_SUB_FLT + bit_off};
      ST_SUB_ENA:  addr_o = {unit_field, OFF_SUB_ENA + bit_off};
      default:     addr_o = '0;
    endcase
  end
endmodule

// File: rtl/fdw_bit_scan.sv
module fdw_bit_scan #(
  parameter int MASK_W = 64,
  localparam int IDX_W = $clog2(MASK_W),
  localparam int FROM_W = IDX_W + 1
) (
  input  logic [MASK_W-1:0] mask_i,
  input  logic              all_i,
  input  logic [FROM_W-1:0] from_i,
  output logic              found_o,
  output logic [IDX_W-1:0]  idx_o
);
  logic [MASK_W-1:0] eff;
  assign eff = all_i ? '1 : mask_i;

  // descending loop so the lowest qualifying bit wins
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int k = MASK_W - 1; k >= 0; k--) begin
      if (eff[k] && (FROM_W'(k) >= from_i)) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(k);
      end
    end
  end
endmodule

// File: rtl/fdw_rec_writer.sv
module fdw_rec_writer
  import fdw_pkg::*;
#(
  parameter int  BUF_DEPTH = 256,
  localparam int BUF_AW = $clog2(BUF_DEPTH),
  localparam int CNT_W  = $clog2(BUF_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              rec_vld_i,
  input  logic [31:0]       rec_addr_i,
  input  logic [63:0]       rec_data_i,
  input  logic              fill_i,
  output logic              full_o,
  output logic              buf_we_o,
  output logic [BUF_AW-1:0] buf_idx_o,
  output logic [31:0]       buf_addr_o,
  output logic [63:0]       buf_data_o,
  output logic              overflow_o,
  output logic [CNT_W-1:0]  rec_count_o
);
  logic [CNT_W-1:0] slot_q;

  assign full_o = (slot_q == CNT_W'(BUF_DEPTH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q      <= '0;
      buf_we_o    <= 1'b0;
      buf_idx_o   <= '0;
      buf_addr_o  <= '0;
      buf_data_o  <= '0;
      overflow_o  <= 1'b0;
      rec_count_o <= '0;
    end else if (clr_i) begin
      slot_q      <= '0;
      buf_we_o    <= 1'b0;
      overflow_o  <= 1'b0;
      rec_count_o <= '0;
    end else begin
      buf_we_o <= 1'b0;
      if (rec_vld_i) begin
        if (!full_o) begin
          buf_we_o    <= 1'b1;
          buf_idx_o   <= slot_q[BUF_AW-1:0];
          buf_addr_o  <= rec_addr_i;
          buf_data_o  <= rec_data_i;
          slot_q      <= slot_q + 1'b1;
          rec_count_o <= rec_count_o + 1'b1;
        end else begin
          overflow_o <= 1'b1;
        end
      end else if (fill_i && !full_o) begin
        buf_we_o   <= 1'b1;
        buf_idx_o  <= slot_q[BUF_AW-1:0];
        buf_addr_o <= INVALID_ADDR;
        buf_data_o <= '1;
        slot_q     <= slot_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fault_dump_walker.sv
module fault_dump_walker
  import fdw_pkg::*;
#(
  parameter int          NUM_UNITS      = 16,
  parameter int          BUF_DEPTH      = 256,
  parameter logic [31:0] GLB_FAULT_ADDR = 32'h0000_0028,
  parameter logic [31:0] INFRA_CFG_ADDR = 32'h0000_0000,
  parameter logic [31:0] APP_CFG_ADDR   = 32'h0200_0000,
  localparam int BUF_AW = $clog2(BUF_DEPTH),
  localparam int CNT_W  = $clog2(BUF_DEPTH + 1),
  localparam int UNIT_W = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              all_mode_i,
  output logic              rd_req_o,
  output logic [31:0]       rd_addr_o,
  input  logic              rd_ack_i,
  input  logic [63:0]       rd_data_i,
  output logic              buf_we_o,
  output logic [BUF_AW-1:0] buf_idx_o,
  output logic [31:0]       buf_addr_o,
  output logic [63:0]       buf_data_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              overflow_o,
  output logic [CNT_W-1:0]  rec_count_o
);
  walk_st_e          st_q, st_d;
  logic [UNIT_W-1:0] unit_q, unit_d;
  logic [5:0]        bit_q, bit_d;
  logic [63:0]       mask_q, mask_d;
  logic              mode_q;
  logic              ack, clr, full;
  logic              scan_found;
  logic [5:0]        scan_idx;
  logic [6:0]        scan_from;
  logic              last_unit;

  assign rd_req_o  = (st_q == ST_GLB) || (st_q == ST_ICFG) || (st_q == ST_ACFG) ||
                     (st_q == ST_UNIT_FLT) || (st_q == ST_UNIT_ENA) ||
                     (st_q == ST_SUB_FLT) || (st_q == ST_SUB_ENA);
  assign ack       = rd_req_o && rd_ack_i;
  assign clr       = (st_q == ST_IDLE) && start_i;
  assign busy_o    = (st_q != ST_IDLE);
  assign done_o    = (st_q == ST_DONE);
  assign last_unit = (unit_q == UNIT_W'(NUM_UNITS - 1));
  assign scan_from = (st_q == ST_SUB_ENA) ? ({1'b0, bit_q} + 7'd1) : 7'd0;

  fdw_addr_gen #(
    .UNIT_W        (UNIT_W),
    .GLB_FAULT_ADDR(GLB_FAULT_ADDR),
    .INFRA_CFG_ADDR(INFRA_CFG_ADDR),
    .APP_CFG_ADDR  (APP_CFG_ADDR)
  ) u_addr (
    .st_i  (st_q),
    .unit_i(unit_q),
    .bit_i (bit_q),
    .addr_o(rd_addr_o)
  );

  fdw_bit_scan #(.MASK_W(64)) u_scan (
    .mask_i (mask_q),
    .all_i  (mode_q),
    .from_i (scan_from),
    .found_o(scan_found),
    .idx_o  (scan_idx)
  );

  fdw_rec_writer #(.BUF_DEPTH(BUF_DEPTH)) u_wr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (clr),
    .rec_vld_i  (ack),
    .rec_addr_i (rd_addr_o),
    .rec_data_i (rd_data_i),
    .fill_i     (st_q == ST_FILL),
    .full_o     (full),
    .buf_we_o   (buf_we_o),
    .buf_idx_o  (buf_idx_o),
    .buf_addr_o (buf_addr_o),
    .buf_data_o (buf_data_o),
    .overflow_o (overflow_o),
    .rec_count_o(rec_count_o)
  );

  always_comb begin
    st_d   = st_q;
    unit_d = unit_q;
    bit_d  = bit_q;
    mask_d = mask_q;
    unique case (st_q)
      ST_IDLE: if (start_i) st_d = ST_GLB;
      ST_GLB:  if (ack) st_d = ST_ICFG;
      ST_ICFG: if (ack) st_d = ST_ACFG;
      ST_ACFG: if (ack) begin
        st_d   = ST_UNIT_FLT;
        unit_d = '0;
      end
      ST_UNIT_FLT: if (ack) begin
        mask_d = rd_data_i;
        st_d   = ST_UNIT_ENA;
      end
      ST_UNIT_ENA, ST_SUB_ENA: if (ack) begin
        if (scan_found) begin
          bit_d = scan_idx;
          st_d  = ST_SUB_FLT;
        end else if (last_unit) begin
          st_d = ST_FILL;
        end else begin
          unit_d = unit_q + 1'b1;
          st_d   = ST_UNIT_FLT;
        end
      end
      ST_SUB_FLT: if (ack) st_d = ST_SUB_ENA;
      ST_FILL:    if (full) st_d = ST_DONE;
      ST_DONE:    st_d = ST_IDLE;
      default:    st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      unit_q <= '0;
      bit_q  <= '0;
      mask_q <= '0;
      mode_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      unit_q <= unit_d;
      bit_q  <= bit_d;
      mask_q <= mask_d;
      if (clr) mode_q <= all_mode_i;
    end
  end
endmodule

// File: rtl/fdw_checker.sv
module fdw_checker #(
  parameter int  BUF_DEPTH = 256,
  localparam int CNT_W = $clog2(BUF_DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rd_req_o,
  input logic             rd_ack_i,
  input logic [31:0]      rd_addr_o,
  input logic             buf_we_o,
  input logic             busy_o,
  input logic             done_o,
  input logic             overflow_o,
  input logic [CNT_W-1:0] rec_count_o
);
  p_req_held_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && !rd_ack_i) |=> (rd_req_o && $stable(rd_addr_o)));

  p_ovf_full_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overflow_o) |-> (rec_count_o == CNT_W'(BUF_DEPTH)));

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o));

  p_done_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!rd_req_o && !buf_we_o));

  p_req_busy_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> busy_o);
endmodule

bind fault_dump_walker fdw_checker #(.BUF_DEPTH(BUF_DEPTH)) u_fdw_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rd_req_o   (rd_req_o),
  .rd_ack_i   (rd_ack_i),
  .rd_addr_o  (rd_addr_o),
  .buf_we_o   (buf_we_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .overflow_o (overflow_o),
  .rec_count_o(rec_count_o)
);

// File: tb/fault_dump_walker_test.sv
module fault_dump_walker_test;
  localparam int NU    = 3;
  localparam int DEPTH = 32;
  localparam int AW    = $clog2(DEPTH);
  localparam int CW    = $clog2(DEPTH + 1);
  localparam logic [31:0] GLB_A = 32'h0000_0028;
  localparam logic [31:0] ICF_A = 32'h0000_0000;
  localparam logic [31:0] ACF_A = 32'h0200_0000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic all_mode_i = 1'b0;
  logic rd_ack_i = 1'b0;
  logic [63:0] rd_data_i = '0;
  logic rd_req_o, buf_we_o, busy_o, done_o, overflow_o;
  logic [31:0] rd_addr_o, buf_addr_o;
  logic [63:0] buf_data_o;
  logic [AW-1:0] buf_idx_o;
  logic [CW-1:0] rec_count_o;

  always #10 clk = ~clk;

  fault_dump_walker #(.NUM_UNITS(NU), .BUF_DEPTH(DEPTH)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .all_mode_i(all_mode_i),
    .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_ack_i(rd_ack_i),
    .rd_data_i(rd_data_i), .buf_we_o(buf_we_o), .buf_idx_o(buf_idx_o),
    .buf_addr_o(buf_addr_o), .buf_data_o(buf_data_o), .busy_o(busy_o),
    .done_o(done_o), .overflow_o(overflow_o), .rec_count_o(rec_count_o));

  int n_tests = 0;
  int n_fail  = 0;
  logic [63:0] mask_tb [NU];
  logic [31:0] exp_a [DEPTH];
  logic [63:0] exp_d [DEPTH];
  int exp_n;
  int lat = 0;
  int wr_seen, fill_seen, mism;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] model(input logic [31:0] a);
    if (a[23:0] == 24'h000008 && int'(a[31:24]) < NU) return mask_tb[a[31:24]];
    return {a ^ 32'h5A5A_0000, ~a};
  endfunction

  function automatic void push(input logic [31:0] a);
    if (exp_n < DEPTH) begin
      exp_a[exp_n] = a;
      exp_d[exp_n] = model(a);
    end
    exp_n++;
  endfunction

  function automatic void build(input bit all_m);
    exp_n = 0;
    push(GLB_A); push(ICF_A); push(ACF_A);
    for (int u = 0; u < NU; u++) begin
      push({8'(u), 24'h000008});
      push({8'(u), 24'h000018});
      for (int j = 0; j < 64; j++)
        if (all_m || mask_tb[u][j]) begin
          push({8'(u), 24'h000100 + 24'(8 * j)});
          push({8'(u), 24'h000300 + 24'(8 * j)});
        end
    end
    for (int k = exp_n; k < DEPTH; k++) begin
      exp_a[k] = 32'hFFFF_FFFF;
      exp_d[k] = '1;
    end
  endfunction

  // read responder
  initial begin
    int wc = 0;
    forever begin
      @(negedge clk);
      rd_ack_i = 1'b0;
      if (rd_req_o) begin
        if (wc >= lat) begin
          rd_ack_i  = 1'b1;
          rd_data_i = model(rd_addr_o);
          wc = 0;
        end else wc++;
      end
    end
  end

  // buffer monitor
  initial begin
    forever begin
      @(negedge clk);
      if (buf_we_o) begin
        wr_seen++;
        if (buf_addr_o == 32'hFFFF_FFFF) fill_seen++;
        if (exp_a[buf_idx_o] !== buf_addr_o || exp_d[buf_idx_o] !== buf_data_o) begin
          if (mism == 0)
            $display("  first mismatch idx %0d addr %h exp %h", buf_idx_o, buf_addr_o, exp_a[buf_idx_o]);
          mism++;
        end
      end
    end
  end

  task automatic run_case(input string tag, input bit all_m, input int l, input bit restart_mid);
    int cnt, guard;
    bit ovf;
    build(all_m);
    cnt = (exp_n > DEPTH) ? DEPTH : exp_n;
    ovf = (exp_n > DEPTH);
    lat = l;
    wr_seen = 0; fill_seen = 0; mism = 0;
    @(negedge clk);
    all_mode_i = all_m;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    all_mode_i = ~all_m;
    if (restart_mid) begin
      repeat (7) @(negedge clk);
      start_i = 1'b1;   // R10: ignored while busy
      @(negedge clk);
      start_i = 1'b0;
    end
    guard = 0;
    while (!done_o && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    check(done_o, {tag, " R9 done seen"}, done_o, 1);
    check(mism == 0, {tag, " R2 R3 R4 R5 record sequence"}, mism, 0);
    check(wr_seen == DEPTH, {tag, " R6 write count"}, wr_seen, DEPTH);
    check(fill_seen == DEPTH - cnt, {tag, " R8 fill count"}, fill_seen, DEPTH - cnt);
    check(int'(rec_count_o) == cnt, {tag, " R9 rec count"}, rec_count_o, cnt);
    check(overflow_o == ovf, {tag, " R7 overflow"}, overflow_o, ovf);
    @(negedge clk);
    check(!done_o && !busy_o, {tag, " R9 done one cycle"}, {done_o, busy_o}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int u = 0; u < NU; u++) mask_tb[u] = '0;
    build(1'b0);
    repeat (3) @(negedge clk);
    check(!rd_req_o && !buf_we_o && !busy_o, "R1 idle in reset", {rd_req_o, buf_we_o, busy_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check(!done_o && !overflow_o && rec_count_o == 0, "R1 status after reset",
          {done_o, overflow_o, 8'(rec_count_o)}, 0);

    // selective, empty masks: 9 records, 23 fill
    run_case("sel_empty", 1'b0, 0, 1'b0);

    // selective, edge bits: 17 records
    mask_tb[0] = 64'h8000_0000_0000_0001;
    mask_tb[1] = '0;
    mask_tb[2] = 64'h0000_0000_0000_0060;
    run_case("sel_edges", 1'b0, 2, 1'b0);

    // 11 flagged bits: 31 records, one fill slot
    mask_tb[0] = 64'h0000_0000_0000_000F;
    mask_tb[1] = 64'hF000_0000_0000_0000;
    mask_tb[2] = 64'h0000_0100_0010_0001;
    run_case("sel_31", 1'b0, 1, 1'b0);

    // 12 flagged bits: 33 records, one dropped
    mask_tb[2] = 64'h0000_1100_0010_0001;
    run_case("sel_33", 1'b0, 0, 1'b0);

    // all mode ignores masks, heavy overflow
    run_case("all", 1'b1, 1, 1'b0);

    // R11: new start clears overflow; R10: mid-walk start ignored
    mask_tb[0] = 64'h0000_0000_0000_0100;
    mask_tb[1] = '0;
    mask_tb[2] = '0;
    run_case("restart", 1'b0, 3, 1'b1);
    check(!overflow_o, "R11 overflow cleared", overflow_o, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule